// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Condition Flags

This block is the arithmetic and logic datapath of a small 8-bit processor. It is purely combinational. Each cycle it takes the accumulator, a second operand, a 4-bit operation code and the current flag byte. It returns an 8-bit result, a write-enable for the accumulator and the new flag byte.

Operand fetch, instruction decode, the register file and memory access all sit outside the block. The surrounding pipeline registers the outputs when it needs them.

Each operation has its own rule for every flag. Some of these rules are unusual:
- A logical AND forces half-carry.
- Increment and decrement leave carry untouched.
- In the carry-using forms, the incoming carry is merged into the second operand before the arithmetic. The flags are then taken from that merged operand.

Decimal adjust is not implemented. Its code, and every unused code, raises an illegal-operation output.

Top module: `alu8_core`

## Requirements
- R1: The flag byte holds zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3..0 of `flags_out` are always 0.
- R2: Operation codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 complement, 11 set carry, 12 complement carry, 13 decimal adjust, 14 and 15 unused. Add returns A+B with subtract cleared, half-carry on a carry out of bit 3, carry on a carry out of bit 7, and zero when the 8-bit result is 0. Add, add-with-carry, subtract, subtract-with-carry, AND, OR, XOR and complement assert `acc_we_out`.
- R3: Add-with-carry and subtract-with-carry first form B' = (B + carry-in) mod 256. They then add or subtract B' exactly as codes 0 and 2 do, and all flags come from B'. For example, B=0xFF with carry-in 1 gives B'=0, so carry comes out clear.
- R4: Subtract returns A-B mod 256. It sets subtract, sets half-carry on a borrow out of the low nibble, sets carry when A<B, and sets zero when the result is 0.
- R5: Compare returns the same result and flags as subtract, but keeps `acc_we_out` low.
- R6: AND returns A&B, sets half-carry, clears subtract and carry, and sets zero from the result.
- R7: OR and XOR return A|B and A^B. Every flag except zero is cleared.
- R8: Increment returns B+1 mod 256 with `acc_we_out` low. It keeps carry, clears subtract, sets half-carry when the result's low nibble is 0, and sets zero when the result is 0.
- R9: Decrement returns B-1 mod 256 with `acc_we_out` low. It keeps carry, sets subtract, sets half-carry when the result's low nibble is 0xF, and sets zero when the result is 0.
- R10: Complement returns ~A with `acc_we_out` high. It sets subtract and half-carry, and keeps zero and carry.
- R11: Set carry and complement carry return A with `acc_we_out` low. Both clear subtract and half-carry and keep zero. Set carry forces carry to 1; complement carry inverts it.
- R12: Codes 13, 14 and 15 raise `illegal_out`, hold `acc_we_out` low, return result 0, and pass `flags_in` through with bits 3..0 cleared. Every legal code keeps `illegal_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B (also the increment/decrement source) |
| op_in | input | 4 | Operation code |
| flags_in | input | 8 | Current flag byte |
| result_out | output | 8 | Operation result |
| acc_we_out | output | 1 | Accumulator write-enable |
| flags_out | output | 8 | New flag byte |
| illegal_out | output | 1 | Unsupported operation code |

## Verification
The bench builds the block with its default `DATA_W` of 8. This makes the whole operand space reachable, including the nibble boundary at bit 3 and the wrap at 0xFF and 0x00.

Random stimulus covers all sixteen operation codes, including the reserved ones, with random flag bytes. This includes dirty low flag bits, which exposes any pass-through of bits 3..0.

Directed cases add the exact wrap points:
- the folded carry on an operand of 0xFF
- equal operands for compare
- increment from 0xFF
- decrement from 0x10

// File: rtl/alu8_pkg.sv
// Package: operation codes and flag bit positions shared by the ALU and its checker.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_CPL  = 4'd10,
        OP_SCF  = 4'd11,
        OP_CCF  = 4'd12,
        OP_DAA  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    localparam int FLG_Z = 7;
    localparam int FLG_N = 6;
    localparam int FLG_H = 5;
    localparam int FLG_C = 4;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag4_t;

endpackage

// File: rtl/alu8_arith.sv
// Module: add/subtract engine. Folds an optional carry-in into operand B
// (truncated to DATA_W bits) before adding or subtracting it from A.
// Assumes DATA_W is even; the half-carry boundary sits at DATA_W/2.
module alu8_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              cin_in,
    input  logic              use_cin,
    input  logic              subtract,
    output logic [DATA_W-1:0] sum_out,
    output logic              half_out,
    output logic              carry_out
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;
    logic [HALF:0]     low;

    // Purpose: merge carry-in into the operand, then form full and low-nibble results.
    always_comb begin
        b_eff = b_in + {{(DATA_W-1){1'b0}}, (use_cin & cin_in)};
        if (subtract) begin
            wide = {1'b0, a_in} - {1'b0, b_eff};
            low  = {1'b0, a_in[HALF-1:0]} - {1'b0, b_eff[HALF-1:0]};
        end else begin
            wide = {1'b0, a_in} + {1'b0, b_eff};
            low  = {1'b0, a_in[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]};
        end
        sum_out   = wide[DATA_W-1:0];
        half_out  = low[HALF];
        carry_out = wide[DATA_W];
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise unit. sel 0 = AND, 1 = OR, 2 = XOR, 3 = complement of A.
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] res_out
);
    // Purpose: pick the bitwise function.
    always_comb begin
        case (sel)
            2'd0:    res_out = a_in & b_in;
            2'd1:    res_out = a_in | b_in;
            2'd2:    res_out = a_in ^ b_in;
            default: res_out = ~a_in;
        endcase
    end
endmodule

// File: rtl/alu8_step.sv
// Module: increment/decrement by one with the nibble-boundary indicator.
// Half flag: low nibble of result all-zero (up) or all-one (down).
module alu8_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_in,
    input  logic              down,
    output logic [DATA_W-1:0] res_out,
    output logic              half_out
);
    localparam int HALF = DATA_W / 2;

    // Purpose: step the value and flag the nibble crossing.
    always_comb begin
        if (down) begin
            res_out  = val_in - {{(DATA_W-1){1'b0}}, 1'b1};
            half_out = &res_out[HALF-1:0];
        end else begin
            res_out  = val_in + {{(DATA_W-1){1'b0}}, 1'b1};
            half_out = ~|res_out[HALF-1:0];
        end
    end
endmodule

// File: rtl/alu8_core.sv
// Module: top of the ALU. Purely combinational; decodes the operation code,
// steers operands to the sub-units and applies the per-operation flag policy.
// Assumes the caller registers outputs and performs the accumulator write.
module alu8_core #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [3:0]        op_in,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result_out,
    output logic              acc_we_out,
    output logic [7:0]        flags_out,
    output logic              illegal_out
);
    import alu8_pkg::*;

    alu_op_e           op;
    flag4_t            fin;
    flag4_t            fnew;
    logic              ar_sub, ar_cin;
    logic [DATA_W-1:0] ar_sum;
    logic              ar_h, ar_c;
    logic [1:0]        lg_sel;
    logic [DATA_W-1:0] lg_res;
    logic              st_down;
    logic [DATA_W-1:0] st_res;
    logic              st_h;

    // Purpose: decode the operation code and select sub-unit controls.
    always_comb begin
        op      = alu_op_e'(op_in);
        fin     = flag4_t'(flags_in[7:4]);
        ar_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        ar_cin  = (op == OP_ADC) || (op == OP_SBC);
        st_down = (op == OP_DEC);
        case (op)
            OP_AND:  lg_sel = 2'd0;
            OP_OR:   lg_sel = 2'd1;
            OP_XOR:  lg_sel = 2'd2;
            default: lg_sel = 2'd3;
        endcase
    end

    alu8_arith #(.DATA_W(DATA_W)) u_arith (
        .a_in     (acc_in),
        .b_in     (opnd_in),
        .cin_in   (fin.c),
        .use_cin  (ar_cin),
        .subtract (ar_sub),
        .sum_out  (ar_sum),
        .half_out (ar_h),
        .carry_out(ar_c)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a_in   (acc_in),
        .b_in   (opnd_in),
        .sel    (lg_sel),
        .res_out(lg_res)
    );

    alu8_step #(.DATA_W(DATA_W)) u_step (
        .val_in  (opnd_in),
        .down    (st_down),
        .res_out (st_res),
        .half_out(st_h)
    );

    // Purpose: choose the result, write-enable and flags per operation.
    always_comb begin
        result_out  = '0;
        acc_we_out  = 1'b0;
        illegal_out = 1'b0;
        fnew        = fin;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                result_out = ar_sum;
                acc_we_out = (op != OP_CMP);
                fnew.z     = ~|ar_sum;
                fnew.n     = ar_sub;
                fnew.h     = ar_h;
                fnew.c     = ar_c;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_out = lg_res;
                acc_we_out = 1'b1;
                fnew.z     = ~|lg_res;
                fnew.n     = 1'b0;
                fnew.h     = (op == OP_AND);
                fnew.c     = 1'b0;
            end
            OP_INC, OP_DEC: begin
                result_out = st_res;
                fnew.z     = ~|st_res;
                fnew.n     = st_down;
                fnew.h     = st_h;
            end
            OP_CPL: begin
                result_out = lg_res;
                acc_we_out = 1'b1;
                fnew.n     = 1'b1;
                fnew.h     = 1'b1;
            end
            OP_SCF, OP_CCF: begin
                result_out = acc_in;
                fnew.n     = 1'b0;
                fnew.h     = 1'b0;
                fnew.c     = (op == OP_SCF) ? 1'b1 : ~fin.c;
            end
            default: begin
                illegal_out = 1'b1;
            end
        endcase
        flags_out = {fnew, 4'b0000};
    end
endmodule

// File: rtl/alu8_core_chk.sv
// Module: checker bound to alu8_core. Immediate assertions on the settled
// combinational outputs; the block has no clock or reset of its own.
module alu8_core_chk #(
    parameter int DATA_W = 8
) (
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [3:0]        op_in,
    input logic [7:0]        flags_in,
    input logic [DATA_W-1:0] result_out,
    input logic              acc_we_out,
    input logic [7:0]        flags_out,
    input logic              illegal_out
);
    import alu8_pkg::*;

    // Purpose: check cross-unit invariants whenever the inputs are known.
    always_comb begin
        if (!$isunknown({op_in, flags_in, acc_in, opnd_in})) begin
            AST_LOW_FLAGS_ZERO: assert (flags_out[3:0] == 4'b0000);  // R1
            AST_CMP_NO_WRITE: assert (op_in != OP_CMP || !acc_we_out);  // R5
            AST_STEP_KEEPS_CARRY: assert (!(op_in == OP_INC || op_in == OP_DEC)
                || (flags_out[FLG_C] == flags_in[FLG_C] && !acc_we_out));  // R8
            AST_LOGIC_CLEARS: assert (!(op_in == OP_AND || op_in == OP_OR || op_in == OP_XOR)
                || (!flags_out[FLG_N] && !flags_out[FLG_C]
                    && flags_out[FLG_Z] == (result_out == '0)));  // R6
            AST_ILLEGAL_QUIET: assert (!illegal_out
                || (!acc_we_out && result_out == '0));  // R12
            AST_CPL_INVERTS: assert (op_in != OP_CPL || result_out == ~acc_in);  // R10
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
    .acc_in     (acc_in),
    .opnd_in    (opnd_in),
    .op_in      (op_in),
    .flags_in   (flags_in),
    .result_out (result_out),
    .acc_we_out (acc_we_out),
    .flags_out  (flags_out),
    .illegal_out(illegal_out)
);

// File: tb/alu8_core_test.sv
// Bench: drives the ALU through a registered capture stage, compares against
// a reference function written from the requirements.
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] acc, opnd, flg;
    logic [3:0] op;
    logic [7:0] res;
    logic       we, ill;
    logic [7:0] fo;
    logic [7:0] cap_res, cap_fo;
    logic       cap_we, cap_ill;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    alu8_core uut (
        .acc_in     (acc),
        .opnd_in    (opnd),
        .op_in      (op),
        .flags_in   (flg),
        .result_out (res),
        .acc_we_out (we),
        .flags_out  (fo),
        .illegal_out(ill)
    );

    // Purpose: registered wrapper sampling outputs on each valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_res <= '0; cap_fo <= '0; cap_we <= 1'b0; cap_ill <= 1'b0;
        end else if (vld) begin
            cap_res <= res; cap_fo <= fo; cap_we <= we; cap_ill <= ill;
        end
    end

    // Reference: returns {illegal, we, flags[7:0], result[7:0]}.
    function automatic logic [17:0] ref_model(input logic [3:0] o, input logic [7:0] a,
                                              input logic [7:0] b, input logic [7:0] f);
        int ai = int'(a), bi = int'(b), r = 0;
        bit z, n, h, c, w, il;
        z = f[7]; n = f[6]; h = f[5]; c = f[4]; w = 0; il = 0;
        case (o)
            4'd0, 4'd1: begin
                if (o == 4'd1) bi = (bi + int'(f[4])) % 256;
                r = ai + bi; h = ((ai % 16) + (bi % 16)) > 15; c = r > 255;
                r = r % 256; n = 0; z = (r == 0); w = 1;
            end
            4'd2, 4'd3, 4'd4: begin
                if (o == 4'd3) bi = (bi + int'(f[4])) % 256;
                h = (ai % 16) < (bi % 16); c = ai < bi;
                r = (ai - bi + 256) % 256; n = 1; z = (r == 0); w = (o != 4'd4);
            end
            4'd5: begin r = int'(a & b); z = (r == 0); n = 0; h = 1; c = 0; w = 1; end
            4'd6: begin r = int'(a | b); z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            4'd7: begin r = int'(a ^ b); z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            4'd8: begin r = (bi + 1) % 256; z = (r == 0); n = 0; h = (r % 16) == 0; end
            4'd9: begin r = (bi + 255) % 256; z = (r == 0); n = 1; h = (r % 16) == 15; end
            4'd10: begin r = int'(~a); n = 1; h = 1; w = 1; end
            4'd11: begin r = ai; n = 0; h = 0; c = 1; end
            4'd12: begin r = ai; n = 0; h = 0; c = !c; end
            default: begin r = 0; il = 1; end
        endcase
        return {il, w, z, n, h, c, 4'b0000, 8'(r)};
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R2";   4'd1: return "R3";  4'd2: return "R4";
            4'd3: return "R3";   4'd4: return "R5";  4'd5: return "R6";
            4'd6, 4'd7: return "R7";                  4'd8: return "R8";
            4'd9: return "R9";   4'd10: return "R10";
            4'd11, 4'd12: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Purpose: apply one operation, capture it, and compare with the reference.
    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] f, input string tag);
        logic [17:0] exp, got;
        @(negedge clk);
        op = o; acc = a; opnd = b; flg = f; vld = 1'b1;
        @(posedge clk);
        #1;
        vld = 1'b0;
        exp = ref_model(o, a, b, f);
        got = {cap_ill, cap_we, cap_fo, cap_res};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got ill=%0b we=%0b flags=%02h res=%02h expected ill=%0b we=%0b flags=%02h res=%02h",
                     tag, o, a, b, f, got[17], got[16], got[15:8], got[7:0],
                     exp[17], exp[16], exp[15:8], exp[7:0]);
        end
        if (got[11:8] !== 4'b0000) begin
            errors++;
            $display("FAIL R1 low flag bits got=%01h expected=0", got[11:8]);
        end
    endtask

    initial begin
        op = '0; acc = '0; opnd = '0; flg = '0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({cap_ill, cap_we, cap_fo, cap_res} !== 18'd0) begin
            errors++;
            $display("FAIL R1 reset capture got=%05h expected=00000", {cap_ill, cap_we, cap_fo, cap_res});
        end
        @(negedge clk);
        rst_n = 1'b1;

        run_op(4'd0, 8'h0F, 8'h01, 8'h00, "R2");  // half-carry out of bit 3
        run_op(4'd0, 8'h80, 8'h80, 8'h00, "R2");  // zero and carry
        run_op(4'd1, 8'h10, 8'hFF, 8'h10, "R3");  // folded carry wraps operand to 0
        run_op(4'd3, 8'h10, 8'hFF, 8'h10, "R3");  // folded borrow wraps operand to 0
        run_op(4'd2, 8'h10, 8'h01, 8'h00, "R4");  // nibble borrow
        run_op(4'd2, 8'h01, 8'h02, 8'h00, "R4");  // full borrow
        run_op(4'd4, 8'h42, 8'h42, 8'h00, "R5");  // equal compare, no write
        run_op(4'd5, 8'hF0, 8'h0F, 8'h1F, "R6");
        run_op(4'd6, 8'h00, 8'h00, 8'hFF, "R7");
        run_op(4'd7, 8'hA5, 8'hA5, 8'h30, "R7");
        run_op(4'd8, 8'h00, 8'hFF, 8'h10, "R8");  // wrap to 0, carry kept
        run_op(4'd9, 8'h00, 8'h10, 8'h00, "R9");  // 0x10 -> 0x0F
        run_op(4'd9, 8'h00, 8'h01, 8'h10, "R9");
        run_op(4'd10, 8'h5A, 8'h00, 8'h90, "R10");
        run_op(4'd11, 8'h33, 8'h00, 8'hE0, "R11");
        run_op(4'd12, 8'h33, 8'h00, 8'h90, "R11");
        run_op(4'd13, 8'h99, 8'h01, 8'hFF, "R12");
        run_op(4'd15, 8'h01, 8'h01, 8'hA5, "R12");

        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom);
            run_op(ro, 8'($urandom), 8'($urandom), 8'($urandom), req_of(ro));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Purpose: watchdog ending a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule